// File: doc/BRIEF.md
# Serial Link Synchronization Monitor

This block sits right after the 8B/10B decoder in a serial link receiver. On each clock it takes one decoded character with a qualifying strobe and a two-bit kind code. It tracks whether the link is locked by moving between three modes: hunting, locked and checking.

While it is hunting, the block waits for evidence of alignment. That evidence is either a short run of fill characters (idle or carrier-extend) or a single valid data character. Once the link is locked, one bad code sends the block into a checking mode. In checking mode, a run of bad codes drops the link back to hunting, and a run of good characters restores the lock.

Data bytes pass to the output stream only while the link reports sync. The output is a valid-only stream with no ready signal. A receive path cannot be stalled, so the consumer must accept every beat in the cycle it is presented. There is no back-pressure.

Top module: `lsync_link_monitor`

## Requirements
- R1: A synchronous active-high reset puts the block in hunting mode (`link_mode` = 2'b00) with `link_sync` and `out_valid` low.
- R2: In hunting mode, three consecutive strobed fill characters move the block to locked mode (`link_mode` = 2'b01). A fill character is idle (kind 2'b00) or carrier-extend (kind 2'b01), and the two may be mixed in the run. A bad code (kind 2'b11) restarts the run.
- R3: In hunting mode, one strobed data character (kind 2'b10) moves the block to locked mode. That character is not forwarded.
- R4: A strobed data character received while `link_sync` is high appears on `out_data` with `out_valid` high one cycle later, in arrival order. No other character is forwarded.
- R5: In locked mode, one strobed bad code moves the block to checking mode (`link_mode` = 2'b10) on that character.
- R6: In checking mode, four consecutive strobed bad codes return the block to hunting mode. Any good character restarts that run. The bad code that caused entry into checking mode does not count.
- R7: In checking mode, four consecutive strobed good characters (any kind except bad) return the block to locked mode. A bad code restarts that run.
- R8: A character presented with `chr_valid` low changes neither the mode, nor any run count, nor the output stream.
- R9: `link_sync` is high in locked and checking modes and low in hunting mode.
- R10: Mode changes take effect at the clock edge that samples the character and are visible in the following cycle. All run counters restart on every mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous reset, active high |
| chr_valid | input | 1 | Qualifies the character in this cycle |
| chr_kind | input | 2 | 00 idle, 01 carrier-extend, 10 data, 11 bad code |
| chr_data | input | DATA_W | Decoded byte |
| link_mode | output | 2 | 00 hunting, 01 locked, 10 checking |
| link_sync | output | 1 | High while locked or checking |
| out_valid | output | 1 | Forwarded byte valid |
| out_data | output | DATA_W | Forwarded byte |

## Verification
The character sampled at one rising edge determines `link_mode` and `link_sync` after that edge. When it is forwarded, it also appears on `out_valid`/`out_data` after that same edge. Every result is therefore due exactly one cycle after its stimulus.

The driver changes inputs on the falling edge. It then compares the mode and sync flag against a reference model at the next falling edge, when they must already reflect that character. Expected bytes go into a queue as each character is driven. A monitor pops the queue at every falling edge where `out_valid` is high, so an extra, missing or reordered byte shows up as a mismatch, an unexpected beat, or a non-empty queue at the drain points.

// File: rtl/lsync_pkg.sv
package lsync_pkg;

  typedef enum logic [1:0] {
    CH_IDLE   = 2'b00,
    CH_CAREXT = 2'b01,
    CH_DATA   = 2'b10,
    CH_BAD    = 2'b11
  } chr_kind_e;

  typedef enum logic [1:0] {
    LM_HUNT   = 2'b00,
    LM_LOCKED = 2'b01,
    LM_CHECK  = 2'b10
  } link_mode_e;

endpackage

// File: rtl/lsync_run_counter.sv
// Counts consecutive qualifying events; 'hit' fires on the event completing the run.
module lsync_run_counter #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign hit = inc && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (inc && (cnt_q < CW'(LIMIT - 1))) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R6
  run_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(LIMIT));

  // R10
  run_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/lsync_mode_ctrl.sv
module lsync_mode_ctrl
  import lsync_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       chr_valid,
  input  chr_kind_e  chr_kind,
  input  logic       hunt_hit,
  input  logic       loss_hit,
  input  logic       recover_hit,
  output link_mode_e mode_q,
  output logic       mode_change
);
  link_mode_e mode_d;

  always_comb begin
    mode_d = mode_q;
    if (chr_valid) begin
      unique case (mode_q)
        LM_HUNT:   if (chr_kind == CH_DATA || hunt_hit) mode_d = LM_LOCKED;
        LM_LOCKED: if (chr_kind == CH_BAD) mode_d = LM_CHECK;
        LM_CHECK: begin
          if (loss_hit)         mode_d = LM_HUNT;
          else if (recover_hit) mode_d = LM_LOCKED;
        end
        default:   mode_d = LM_HUNT;
      endcase
    end
  end

  assign mode_change = (mode_d != mode_q);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= LM_HUNT;
    else     mode_q <= mode_d;
  end

  // R3
  hunt_data_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == LM_HUNT && chr_valid && chr_kind == CH_DATA) |=> (mode_q == LM_LOCKED));

  // R5
  locked_bad_check_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == LM_LOCKED && chr_valid && chr_kind == CH_BAD) |=> (mode_q == LM_CHECK));

  // R6
  check_loss_hunt_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == LM_CHECK && loss_hit) |=> (mode_q == LM_HUNT));

  // R7
  check_recover_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == LM_CHECK && recover_hit) |=> (mode_q == LM_LOCKED));

  // R2
  hunt_no_check_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == LM_HUNT) |=> (mode_q != LM_CHECK));

  // R8
  no_strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !chr_valid |=> $stable(mode_q));

endmodule

// File: rtl/lsync_data_gate.sv
module lsync_data_gate
  import lsync_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chr_valid,
  input  chr_kind_e         chr_kind,
  input  logic [DATA_W-1:0] chr_data,
  input  logic              locked,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic fwd;

  assign fwd = chr_valid && (chr_kind == CH_DATA) && locked;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= fwd;
      if (fwd) out_data <= chr_data;
    end
  end

  // R4
  fwd_only_data_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(chr_valid && chr_kind == CH_DATA && locked));

  // R4
  fwd_byte_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data == $past(chr_data)));

endmodule

// File: rtl/lsync_link_monitor.sv
module lsync_link_monitor
  import lsync_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int HUNT_RUN    = 3,
  parameter int LOSS_RUN    = 4,
  parameter int RECOVER_RUN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chr_valid,
  input  logic [1:0]        chr_kind,
  input  logic [DATA_W-1:0] chr_data,
  output logic [1:0]        link_mode,
  output logic              link_sync,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  chr_kind_e  kind;
  link_mode_e mode;
  logic       mode_change;
  logic       is_fill, is_bad, in_hunt, in_check;
  logic       hunt_hit, loss_hit, recover_hit;

  assign kind     = chr_kind_e'(chr_kind);
  assign is_fill  = (kind == CH_IDLE) || (kind == CH_CAREXT);
  assign is_bad   = (kind == CH_BAD);
  assign in_hunt  = chr_valid && (mode == LM_HUNT);
  assign in_check = chr_valid && (mode == LM_CHECK);

  lsync_run_counter #(.LIMIT(HUNT_RUN)) hunt_run_i (
    .clk (clk),
    .rst (rst),
    .clr (mode_change || (in_hunt && !is_fill)),
    .inc (in_hunt && is_fill),
    .hit (hunt_hit)
  );

  lsync_run_counter #(.LIMIT(LOSS_RUN)) loss_run_i (
    .clk (clk),
    .rst (rst),
    .clr (mode_change || (in_check && !is_bad)),
    .inc (in_check && is_bad),
    .hit (loss_hit)
  );

  lsync_run_counter #(.LIMIT(RECOVER_RUN)) recover_run_i (
    .clk (clk),
    .rst (rst),
    .clr (mode_change || (in_check && is_bad)),
    .inc (in_check && !is_bad),
    .hit (recover_hit)
  );

  lsync_mode_ctrl ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .chr_valid   (chr_valid),
    .chr_kind    (kind),
    .hunt_hit    (hunt_hit),
    .loss_hit    (loss_hit),
    .recover_hit (recover_hit),
    .mode_q      (mode),
    .mode_change (mode_change)
  );

  lsync_data_gate #(.DATA_W(DATA_W)) gate_i (
    .clk       (clk),
    .rst       (rst),
    .chr_valid (chr_valid),
    .chr_kind  (kind),
    .chr_data  (chr_data),
    .locked    (mode != LM_HUNT),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  assign link_mode = mode;
  assign link_sync = (mode != LM_HUNT);

  // R9
  sync_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (link_sync == (link_mode != 2'b00)));

endmodule

// File: tb/lsync_link_monitor_tb_top.sv
`timescale 1ns/1ps
module lsync_link_monitor_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       chr_valid;
  logic [1:0] chr_kind;
  logic [7:0] chr_data;
  logic [1:0] link_mode;
  logic       link_sync;
  logic       out_valid;
  logic [7:0] out_data;

  always #2.5 clk = ~clk;

  lsync_link_monitor dut_i (
    .clk       (clk),
    .rst       (rst),
    .chr_valid (chr_valid),
    .chr_kind  (chr_kind),
    .chr_data  (chr_data),
    .link_mode (link_mode),
    .link_sync (link_sync),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  localparam logic [1:0] K_IDLE = 2'b00, K_CX = 2'b01, K_DATA = 2'b10, K_BAD = 2'b11;
  localparam logic [1:0] M_HUNT = 2'b00, M_LOCK = 2'b01, M_CHECK = 2'b10;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];

  logic [1:0] m_mode;
  int m_fill, m_bad, m_good;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic model_clear();
    m_mode = M_HUNT; m_fill = 0; m_bad = 0; m_good = 0;
  endtask

  // Call at a falling edge; leaves the bench at the next falling edge.
  task automatic step(input bit v, input logic [1:0] k, input logic [7:0] d,
                      input string req);
    logic [1:0] nm;
    chr_valid = v; chr_kind = k; chr_data = d;
    if (v) begin
      nm = m_mode;
      if (k == K_DATA && m_mode != M_HUNT) exp_q.push_back(d);
      case (m_mode)
        M_HUNT: begin
          if (k == K_DATA) nm = M_LOCK;
          else if (k == K_BAD) m_fill = 0;
          else begin
            m_fill++;
            if (m_fill == 3) nm = M_LOCK;
          end
        end
        M_LOCK: if (k == K_BAD) nm = M_CHECK;
        default: begin
          if (k == K_BAD) begin
            m_bad++; m_good = 0;
            if (m_bad == 4) nm = M_HUNT;
          end else begin
            m_good++; m_bad = 0;
            if (m_good == 4) nm = M_LOCK;
          end
        end
      endcase
      if (nm != m_mode) begin m_fill = 0; m_bad = 0; m_good = 0; end
      m_mode = nm;
    end
    @(negedge clk);
    chk(link_mode == m_mode, req, "link_mode", link_mode, m_mode);
    chk(link_sync == (m_mode != M_HUNT), "R9", "link_sync", link_sync, m_mode != M_HUNT);
  endtask

  task automatic gap_and_drain(input int n);
    chr_valid = 1'b0;
    repeat (n) @(negedge clk);
    chk(exp_q.size() == 0, "R4", "pending bytes", exp_q.size(), 0);
  endtask

  task automatic do_reset();
    rst = 1'b1; chr_valid = 1'b0; chr_kind = K_IDLE; chr_data = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_clear();
    exp_q.delete();
    chk(link_mode == M_HUNT, "R1", "link_mode", link_mode, M_HUNT);
    chk(link_sync == 1'b0, "R1", "link_sync", link_sync, 0);
    chk(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4", "unexpected byte", out_data, -1);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(out_data == e, "R4", "out_data", out_data, e);
      end
    end
  end

  bit done = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; chr_valid = 1'b0; chr_kind = K_IDLE; chr_data = '0;
    @(negedge clk);
    do_reset();

    // R2: fill run, broken by a bad code, strobe-low gap ignored (R8)
    step(1, K_IDLE, 8'h00, "R2");
    step(1, K_CX,   8'h00, "R2");
    step(1, K_BAD,  8'h00, "R2");
    step(1, K_IDLE, 8'h00, "R2");
    step(1, K_IDLE, 8'h00, "R2");
    step(0, K_BAD,  8'h00, "R8");
    step(1, K_CX,   8'h00, "R2");

    // R4: forwarding while locked; strobe-low data not forwarded (R8)
    step(1, K_DATA, 8'hA1, "R4");
    step(1, K_DATA, 8'hA2, "R4");
    step(0, K_DATA, 8'hEE, "R8");
    step(1, K_DATA, 8'hA3, "R4");
    step(1, K_IDLE, 8'h00, "R4");

    // R5 then R6: loss run broken by good characters
    step(1, K_BAD,  8'h00, "R5");
    step(1, K_DATA, 8'hB1, "R6");
    step(1, K_BAD,  8'h00, "R6");
    step(1, K_BAD,  8'h00, "R6");
    step(1, K_BAD,  8'h00, "R6");
    step(1, K_IDLE, 8'h00, "R6");
    step(1, K_BAD,  8'h00, "R6");
    step(1, K_BAD,  8'h00, "R6");
    step(0, K_IDLE, 8'h00, "R8");
    step(1, K_BAD,  8'h00, "R6");
    step(1, K_BAD,  8'h00, "R6");
    gap_and_drain(3);

    // R3: single data char locks, not forwarded
    step(1, K_DATA, 8'hC1, "R3");
    step(1, K_DATA, 8'hC2, "R4");

    // R7: recovery run broken by a bad code
    step(1, K_BAD,  8'h00, "R5");
    step(1, K_IDLE, 8'h00, "R7");
    step(1, K_DATA, 8'hD1, "R7");
    step(1, K_BAD,  8'h00, "R7");
    step(1, K_IDLE, 8'h00, "R7");
    step(1, K_DATA, 8'hD2, "R7");
    step(1, K_CX,   8'h00, "R7");
    step(0, K_BAD,  8'h00, "R8");
    step(1, K_DATA, 8'hD3, "R7");
    step(1, K_DATA, 8'hE1, "R4");
    gap_and_drain(3);

    // R1: reset in the middle of a locked stream
    step(1, K_DATA, 8'hF1, "R4");
    gap_and_drain(2);
    do_reset();
    step(1, K_IDLE, 8'h00, "R1");
    gap_and_drain(2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule